// File: doc/BRIEF.md
# SDLC receive address filter

This block sits behind a serial line sampler and turns a synchronous bit stream into frame bytes for a receive FIFO. It removes the stuffed zero that a transmitter inserts after every run of five ones. It finds the 8'h7E frame delimiter and packs the surviving data bits into bytes, least significant bit first. The first byte after a delimiter is the station address. When filtering is switched on, that byte decides whether the rest of the frame reaches the FIFO. An own-address match or the all-ones group address lets the frame through. Any other address makes the block drop the frame silently until the next delimiter.

A run of seven ones inside a frame is an abort. It ends the frame, sends the receiver back to delimiter hunting and sets a sticky status bit. That bit reaches the interrupt line only when its enable is set. Software clears it with a one-cycle clear pulse. Decoding happens only on clock edges where the bit strobe is high.

The frame control is a four-state machine. HUNT waits for a delimiter. ADDR assembles the address byte. KEEP writes every completed byte. SKIP discards bytes.
- A delimiter moves any state to ADDR.
- An abort moves any state to HUNT.
- Clearing the receive enable moves any state to HUNT.
- A completed address byte moves ADDR to KEEP when accepted and to SKIP when refused.

A hold line of seven decoded bits sits between the line decoder and the byte packer. Because of it, the bits that belong to a delimiter or an abort never reach the packer.

Top module: `sdlc_rx_filter`

## Requirements
- R1: While `rx_en` is 0 (its value after reset), the line is ignored, no byte is written and the decoder returns to HUNT with an empty hold line.
- R2: The pattern 0, six 1s, 0 is a delimiter: from any state it starts a new frame in ADDR and discards any byte only partly assembled.
- R3: With `match_en` = 1, a frame's bytes are written only if its address byte equals `own_addr`.
- R4: With `match_en` = 1, a frame whose address byte is 8'hFF is always accepted.
- R5: With `match_en` = 0, the bytes of every frame are written.
- R6: Bits arrive LSB first; the address byte is written first, then each later byte, each as a one-cycle `wr_en` pulse with `wr_data`.
- R7: Inside a frame, a 0 that follows five consecutive 1s is deleted and never reaches a byte.
- R8: Seven consecutive 1s after the address byte is complete form an abort. The abort sets `abort_sts`, drops the byte in progress and returns to HUNT. Seven 1s seen while the address is still being assembled return to HUNT without setting status.
- R9: A refused frame writes no byte at all up to the next delimiter.
- R10: `abort_sts` is 0 after reset, stays 1 until a cycle with `abort_clr` = 1, and a new abort in the same cycle wins over the clear.
- R11: `abort_irq` equals `abort_sts` when `abort_ie` = 1 and is 0 when `abort_ie` = 0.
- R12: Clock edges where `bit_vld` = 0 change no decoder or frame state, whatever `bit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable |
| match_en | input | 1 | Station address filtering enable |
| abort_ie | input | 1 | Abort interrupt enable |
| own_addr | input | DATA_W (8) | Station address |
| bit_vld | input | 1 | Strobe: `bit_in` is a new line bit |
| bit_in | input | 1 | Serial line bit |
| abort_clr | input | 1 | Write-one-to-clear pulse for `abort_sts` |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | DATA_W (8) | Byte for the FIFO |
| abort_sts | output | 1 | Sticky abort status |
| abort_irq | output | 1 | Abort interrupt |

## Verification
The bench builds the block with its defaults: 8-bit bytes and stuffing after a run of five ones. With these values the all-ones group address 8'hFF and a data byte of 8'h7E can be sent. That 8'h7E, once stuffed, looks almost like a delimiter. Frames end on byte boundaries, and one stray bit is placed just before a delimiter, so the bench exercises the hold line's discard of delimiter bits and of partial bytes. Aborts are sent both before and after the address byte is complete.

// File: rtl/sdlc_rx_pkg.sv
`timescale 1ns/100ps
package sdlc_rx_pkg;
    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_ADDR = 2'd1,
        S_KEEP = 2'd2,
        S_SKIP = 2'd3
    } rx_state_t;
endpackage

// File: rtl/sdlc_rx_linedec.sv
`timescale 1ns/100ps
module sdlc_rx_linedec #(
    parameter int STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic bit_vld,
    input  logic bit_in,
    output logic ev_flag,
    output logic ev_abort,
    output logic ev_data,
    output logic ev_bit
);
    localparam int HOLD = STUFF_RUN + 2;
    localparam int CW   = $clog2(HOLD + 1);
    localparam logic [CW-1:0] K_STUFF = CW'(STUFF_RUN);
    localparam logic [CW-1:0] K_RUN6  = CW'(STUFF_RUN + 1);
    localparam logic [CW-1:0] K_HOLD  = CW'(HOLD);

    logic [CW-1:0]   ones_q;
    logic [CW-1:0]   fill_q;
    logic [HOLD-1:0] dly_q;
    logic            live, raw_push;

    always_comb begin
        live     = rx_en && bit_vld;
        ev_flag  = live && !bit_in && (ones_q == K_RUN6);
        ev_abort = live &&  bit_in && (ones_q == K_RUN6);
        raw_push = live && (bit_in ? (ones_q < K_RUN6)
                                   : (ones_q != K_STUFF && ones_q != K_RUN6));
        ev_data  = raw_push && (fill_q == K_HOLD);
        ev_bit   = dly_q[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
            fill_q <= '0;
            dly_q  <= '0;
        end else if (!rx_en) begin
            ones_q <= '0;
            fill_q <= '0;
        end else if (bit_vld) begin
            if (bit_in) begin
                if (ones_q != K_HOLD) ones_q <= ones_q + 1'b1;
            end else begin
                ones_q <= '0;
            end
            if (ev_flag || ev_abort) begin
                fill_q <= '0;
            end else if (raw_push) begin
                dly_q <= {bit_in, dly_q[HOLD-1:1]};
                if (fill_q != K_HOLD) fill_q <= fill_q + 1'b1;
            end
        end
    end

    // a delimiter empties the hold line, so no bit leaves it on the next edge
    p_flag_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flag |=> !ev_data);
endmodule

// File: rtl/sdlc_rx_framer.sv
`timescale 1ns/100ps
module sdlc_rx_framer
    import sdlc_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              match_en,
    input  logic [DATA_W-1:0] own_addr,
    input  logic              ev_flag,
    input  logic              ev_abort,
    input  logic              ev_data,
    input  logic              ev_bit,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              abort_hit
);
    localparam int BCW = $clog2(DATA_W);
    localparam logic [BCW-1:0]    LAST  = BCW'(DATA_W - 1);
    localparam logic [DATA_W-1:0] BCAST = {DATA_W{1'b1}};

    rx_state_t         st_q, st_d;
    logic [BCW-1:0]    cnt_q, cnt_d;
    logic [DATA_W-1:0] sr_q, sr_d, byte_now;
    logic              byte_done, addr_ok, wr_d;

    always_comb begin
        byte_now  = {ev_bit, sr_q[DATA_W-1:1]};
        byte_done = ev_data && (cnt_q == LAST) && (st_q != S_HUNT);
        addr_ok   = !match_en || (byte_now == own_addr) || (byte_now == BCAST);
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        sr_d  = sr_q;
        if (!rx_en) begin
            st_d  = S_HUNT;
            cnt_d = '0;
        end else if (ev_flag) begin
            st_d  = S_ADDR;
            cnt_d = '0;
        end else if (ev_abort) begin
            st_d  = S_HUNT;
            cnt_d = '0;
        end else if (ev_data) begin
            unique case (st_q)
                S_HUNT: ;
                S_ADDR: begin
                    sr_d  = byte_now;
                    cnt_d = byte_done ? '0 : cnt_q + 1'b1;
                    if (byte_done) st_d = addr_ok ? S_KEEP : S_SKIP;
                end
                S_KEEP, S_SKIP: begin
                    sr_d  = byte_now;
                    cnt_d = byte_done ? '0 : cnt_q + 1'b1;
                end
                default: st_d = S_HUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_d      = 1'b0;
        abort_hit = 1'b0;
        unique case (st_q)
            S_HUNT: ;
            S_ADDR: wr_d = byte_done && addr_ok && !ev_flag && !ev_abort;
            S_KEEP: begin
                wr_d      = byte_done && !ev_flag && !ev_abort;
                abort_hit = ev_abort && !ev_flag;
            end
            S_SKIP: abort_hit = ev_abort && !ev_flag;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= S_HUNT;
            cnt_q   <= '0;
            sr_q    <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            sr_q    <= sr_d;
            wr_en   <= wr_d;
            wr_data <= byte_now;
        end
    end

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !wr_en);

    p_addr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(st_q) == S_ADDR && $past(match_en))
        |-> (wr_data == $past(own_addr) || wr_data == BCAST));

    p_skip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SKIP) |-> !wr_en);
endmodule

// File: rtl/sdlc_rx_abort.sv
`timescale 1ns/100ps
module sdlc_rx_abort (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_hit,
    input  logic abort_clr,
    input  logic abort_ie,
    output logic abort_sts,
    output logic abort_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         abort_sts <= 1'b0;
        else if (abort_hit) abort_sts <= 1'b1;
        else if (abort_clr) abort_sts <= 1'b0;
    end

    always_comb abort_irq = abort_sts && abort_ie;

    p_abort_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> abort_sts);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_sts && !abort_clr) |=> abort_sts);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_clr && !abort_hit) |=> !abort_sts);
endmodule

// File: rtl/sdlc_rx_filter.sv
`timescale 1ns/100ps
module sdlc_rx_filter #(
    parameter int DATA_W    = 8,
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              match_en,
    input  logic              abort_ie,
    input  logic [DATA_W-1:0] own_addr,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              abort_clr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              abort_sts,
    output logic              abort_irq
);
    logic ev_flag, ev_abort, ev_data, ev_bit, abort_hit;

    sdlc_rx_linedec #(.STUFF_RUN(STUFF_RUN)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .ev_flag  (ev_flag),
        .ev_abort (ev_abort),
        .ev_data  (ev_data),
        .ev_bit   (ev_bit)
    );

    sdlc_rx_framer #(.DATA_W(DATA_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .match_en  (match_en),
        .own_addr  (own_addr),
        .ev_flag   (ev_flag),
        .ev_abort  (ev_abort),
        .ev_data   (ev_data),
        .ev_bit    (ev_bit),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .abort_hit (abort_hit)
    );

    sdlc_rx_abort u_abt (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_hit (abort_hit),
        .abort_clr (abort_clr),
        .abort_ie  (abort_ie),
        .abort_sts (abort_sts),
        .abort_irq (abort_irq)
    );
endmodule

// File: tb/tb_sdlc_rx_filter.sv
`timescale 1ns/100ps
module tb_sdlc_rx_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, match_en = 1'b0, abort_ie = 1'b0;
    logic [7:0] own_addr = 8'h5A;
    logic       bit_vld = 1'b0, bit_in = 1'b0, abort_clr = 1'b0;
    logic       wr_en, abort_sts, abort_irq;
    logic [7:0] wr_data;

    int n_chk = 0, n_err = 0, ones_run = 0, cap_n = 0;
    logic [7:0] cap [0:63];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdlc_rx_filter dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .match_en(match_en),
        .abort_ie(abort_ie), .own_addr(own_addr), .bit_vld(bit_vld),
        .bit_in(bit_in), .abort_clr(abort_clr), .wr_en(wr_en),
        .wr_data(wr_data), .abort_sts(abort_sts), .abort_irq(abort_irq)
    );

    always @(negedge clk) begin
        if (wr_en && cap_n < 64) begin
            cap[cap_n] = wr_data;
            cap_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
        end
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            ones_run++;
            if (ones_run == 5) begin
                send_raw(1'b0);
                ones_run = 0;
            end
        end else begin
            ones_run = 0;
        end
    endtask

    task automatic send_dbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        ones_run = 0;
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] d0,
                              input logic [7:0] d1, input int nd);
        send_flag();
        send_dbyte(a);
        if (nd > 0) send_dbyte(d0);
        if (nd > 1) send_dbyte(d1);
        send_flag();
        idle(4);
    endtask

    task automatic t_reset();
        check("R10 abort_sts after reset", abort_sts, 0);
        check("R11 abort_irq after reset", abort_irq, 0);
        check("R6 wr_en after reset", wr_en, 0);
    endtask

    task automatic t_disabled();
        cap_n = 0;
        rx_en = 1'b0;
        send_frame(8'h33, 8'h44, 8'h55, 2);
        check("R1 writes while disabled", cap_n, 0);
        rx_en = 1'b1;
    endtask

    task automatic t_promisc();
        match_en = 1'b0;
        cap_n = 0;
        send_frame(8'h33, 8'hA5, 8'h3C, 2);
        check("R5 write count promiscuous", cap_n, 3);
        check("R6 address byte first", cap[0], 8'h33);
        check("R6 data byte 1", cap[1], 8'hA5);
        check("R6 data byte 2", cap[2], 8'h3C);
    endtask

    task automatic t_match();
        match_en = 1'b1;
        cap_n = 0;
        send_frame(8'h5A, 8'h11, 8'h00, 1);
        check("R3 write count own address", cap_n, 2);
        check("R3 own address byte", cap[0], 8'h5A);
        check("R3 own data byte", cap[1], 8'h11);
    endtask

    task automatic t_reject();
        match_en = 1'b1;
        cap_n = 0;
        send_frame(8'h5B, 8'h12, 8'h34, 2);
        check("R9 refused frame writes", cap_n, 0);
    endtask

    task automatic t_bcast();
        match_en = 1'b1;
        cap_n = 0;
        send_frame(8'hFF, 8'h77, 8'h00, 1);
        check("R4 broadcast write count", cap_n, 2);
        check("R4 broadcast address", cap[0], 8'hFF);
        check("R4 broadcast data", cap[1], 8'h77);
    endtask

    task automatic t_stuff();
        match_en = 1'b0;
        cap_n = 0;
        send_frame(8'h5A, 8'hFF, 8'h7E, 2);
        check("R7 stuffed frame count", cap_n, 3);
        check("R7 byte FF destuffed", cap[1], 8'hFF);
        check("R7 byte 7E destuffed", cap[2], 8'h7E);
    endtask

    task automatic t_resync();
        match_en = 1'b0;
        cap_n = 0;
        send_flag();
        send_dbyte(8'h5A);
        send_dbit(1'b1);
        send_flag();
        send_dbyte(8'h22);
        send_flag();
        idle(4);
        check("R2 partial byte dropped count", cap_n, 2);
        check("R2 first frame address", cap[0], 8'h5A);
        check("R2 new frame address", cap[1], 8'h22);
    endtask

    task automatic t_strobe();
        match_en = 1'b1;
        cap_n = 0;
        send_flag();
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = ~bit_in;
        end
        send_dbyte(8'h5A);
        send_dbyte(8'hC3);
        send_flag();
        idle(4);
        check("R12 gaps ignored count", cap_n, 2);
        check("R12 gaps ignored data", cap[1], 8'hC3);
    endtask

    task automatic t_abort();
        match_en = 1'b0;
        abort_ie = 1'b0;
        cap_n = 0;
        // abort before address completes: silent
        send_flag();
        repeat (8) send_raw(1'b1);
        idle(3);
        check("R8 early run leaves status clear", abort_sts, 0);
        // abort after the address byte
        send_flag();
        send_dbyte(8'h5A);
        send_dbyte(8'h11);
        repeat (7) send_raw(1'b1);
        ones_run = 0;
        idle(3);
        check("R8 abort sets status", abort_sts, 1);
        check("R8 byte in progress dropped", cap_n, 1);
        check("R11 irq masked", abort_irq, 0);
        send_dbyte(8'h00);
        send_dbyte(8'h5A);
        idle(3);
        check("R8 hunting after abort", cap_n, 1);
        @(negedge clk);
        abort_ie = 1'b1;
        @(negedge clk);
        check("R11 irq enabled", abort_irq, 1);
        idle(5);
        check("R10 status held", abort_sts, 1);
        @(negedge clk);
        abort_clr = 1'b1;
        @(negedge clk);
        abort_clr = 1'b0;
        @(negedge clk);
        check("R10 status cleared", abort_sts, 0);
        check("R11 irq follows clear", abort_irq, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_disabled();
        t_promisc();
        t_match();
        t_reject();
        t_bcast();
        t_stuff();
        t_resync();
        t_strobe();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule